// File: doc/BRIEF.md
# Bus-Request Memory Access Master

This block lets a host side reach the memory of an 8-bit microprocessor by borrowing that processor's external bus. The host first asks the block to take the bus. The block pulls its active-low bus request low and waits for the processor's active-low acknowledge. Only after that does it switch on its 19-bit address drivers. While it owns the bus it runs memory cycles for the host: single reads, single writes, a fill of one constant byte over a run of consecutive addresses, and a block write that draws its bytes one at a time from a stream input. Each cycle drives the active-low memory-request strobe together with either the read strobe or the write strobe. When the host asks to give the bus back, the block turns off its address drivers, raises the request, and reports completion only once the acknowledge has gone high again.

Commands arrive on a one-beat valid/ready port. Every command ends with a one-cycle `done` pulse, and `err` is high in that same cycle when the command was refused. A further output drives the processor's active-low reset, either held at a chosen level or pulsed low for a fixed number of cycles.

The acknowledge and read-data inputs are assumed to be synchronous to `clk`. The data bus is split into an input, an output and an output enable, so that the pad ring can join them into the bidirectional pins.

Top module: `xbus_master`

## Requirements
- R1: After reset `breq_n`, `mreq_n`, `rd_n`, `wr_n` and `cpu_rst_n` are 1, `addr_oe` and `data_oe` are 0, and `cmd_ready` is 1.
- R2: Command code 4 (take) drives `breq_n` low. `addr_oe` rises only in a cycle after `back_n` has been sampled low, and `done` follows once the address drivers are on.
- R3: Command code 5 (give) performs three steps in order. It clears `addr_oe` while `breq_n` is still low. It then raises `breq_n`. It pulses `done` only after `back_n` has been sampled high.
- R4: Command code 1 (write) drives `data_oe` high with `cmd_data` on `data_out`, and pulses `mreq_n` and `wr_n` low together at `cmd_addr`. `rd_n` stays high.
- R5: Command code 0 (read) keeps `data_oe` low, pulses `mreq_n` and `rd_n` low at `cmd_addr`, and returns the byte sampled on `data_in` in the last strobe cycle on `rd_data`.
- R6: Each strobe stays low for exactly STROBE_CYC cycles (default 2). The address is driven for at least one cycle before `mreq_n` falls and stays stable while it is low.
- R7: Command code 2 (fill) writes `cmd_data` to `cmd_len` consecutive addresses, starting at `cmd_addr` and rising by one per byte, with one `mreq_n` pulse per byte.
- R8: Command code 3 (block write) runs `cmd_len` write cycles at consecutive addresses. For each byte it pulses `stream_take` and writes the `stream_data` value present in that cycle.
- R9: A fill or block write with `cmd_len` of 0 runs no memory cycle and still pulses `done`.
- R10: An access command (codes 0 to 3) issued while the bus is not owned runs no memory cycle and returns `done` with `err` high.
- R11: All 19 address bits reach `addr_out`. A write to address 0x7FFFF is strobed at exactly that address.
- R12: Command code 6 sets `cpu_rst_n` to the inverse of `cmd_data[0]`. Command code 7 holds `cpu_rst_n` low for exactly RST_CYC cycles and then releases it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 3 | Command code (0 read, 1 write, 2 fill, 3 block write, 4 take, 5 give, 6 reset level, 7 reset pulse) |
| cmd_addr | input | 19 | Start address |
| cmd_data | input | 8 | Write or fill byte; bit 0 is the reset level |
| cmd_len | input | 16 | Byte count for fill and block write |
| cmd_ready | output | 1 | Block can accept a command |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Command refused (valid with done) |
| rd_data | output | 8 | Byte from the last read |
| stream_data | input | 8 | Next block-write byte |
| stream_take | output | 1 | stream_data consumed this cycle |
| breq_n | output | 1 | Bus request, active low |
| back_n | input | 1 | Bus acknowledge, active low |
| addr_out | output | 19 | Address value |
| addr_oe | output | 1 | Address driver enable |
| data_out | output | 8 | Data bus output value |
| data_in | input | 8 | Data bus input value |
| data_oe | output | 1 | Data driver enable |
| mreq_n | output | 1 | Memory request strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| cpu_rst_n | output | 1 | Processor reset, active low |

## Verification
The hardest situation to reach from the ports is the release sequence, where the address drivers are already off and the request has risen but the acknowledge is still low. In that window the block must wait, and it must not report completion. The bench's processor model returns the acknowledge only after a delay of several cycles, which holds the block in this window for those cycles. Monitors latch any cycle in which the address drivers are on while the acknowledge is high, and any cycle in which the request rises with the drivers on. Refused accesses are checked by counting memory-request falls across the command.

// File: rtl/xbm_pkg.sv
// Package: command codes shared by the bus-request memory master.
// Assumes: codes 0..3 are memory accesses (bit 2 clear); bit 1 set selects a
// multi-byte access whose length comes from the command.
package xbm_pkg;
    typedef enum logic [2:0] {
        OP_READ     = 3'd0,
        OP_WRITE    = 3'd1,
        OP_FILL     = 3'd2,
        OP_STREAM   = 3'd3,
        OP_TAKE     = 3'd4,
        OP_GIVE     = 3'd5,
        OP_RSTLVL   = 3'd6,
        OP_RSTPULSE = 3'd7
    } op_e;
endpackage

// File: rtl/xbm_grant.sv
// Module: bus ownership handshake.
// Does: requests the bus and enables the address drivers only after the
// acknowledge is seen low. On give, it disables the drivers first, drops the
// request next, and finishes once the acknowledge is high again.
// Assumes: back_n is synchronous to clk.
module xbm_grant (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic give,
    input  logic back_n,
    output logic breq_n,
    output logic addr_oe,
    output logic owned,
    output logic busy,
    output logic done
);
    typedef enum logic [2:0] {G_FREE, G_WAIT, G_OWN, G_FLOAT, G_DROP} gstate_e;
    gstate_e state;

    // Purpose: step the ownership sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= G_FREE;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                G_FREE: begin
                    if (take) state <= G_WAIT;
                    else if (give) done <= 1'b1;
                end
                G_WAIT: begin
                    if (!back_n) begin
                        state <= G_OWN;
                        done  <= 1'b1;
                    end
                end
                G_OWN: begin
                    if (give) state <= G_FLOAT;
                    else if (take) done <= 1'b1;
                end
                G_FLOAT: state <= G_DROP;
                G_DROP: begin
                    if (back_n) begin
                        state <= G_FREE;
                        done  <= 1'b1;
                    end
                end
                default: state <= G_FREE;
            endcase
        end
    end

    // Purpose: decode pin levels from the ownership state.
    always_comb begin
        breq_n  = !(state == G_WAIT || state == G_OWN || state == G_FLOAT);
        addr_oe = (state == G_OWN);
        owned   = (state == G_OWN);
        busy    = (state == G_WAIT || state == G_FLOAT || state == G_DROP);
    end
endmodule

// File: rtl/xbm_seq.sv
// Module: memory cycle sequencer.
// Does: runs len read or write cycles at consecutive addresses. Each byte takes
// one setup cycle, STROBE_CYC strobe cycles and one recovery cycle.
// Assumes: the caller starts it only while the bus is owned; data_in is
// synchronous and is sampled in the last strobe cycle.
module xbm_seq #(
    parameter int ADDR_W     = 19,
    parameter int DATA_W     = 8,
    parameter int LEN_W      = 16,
    parameter int STROBE_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_write,
    input  logic              src_stream,
    input  logic [ADDR_W-1:0] addr0,
    input  logic [DATA_W-1:0] fill_byte,
    input  logic [LEN_W-1:0]  len,
    input  logic [DATA_W-1:0] stream_data,
    input  logic [DATA_W-1:0] data_in,
    output logic              stream_take,
    output logic [ADDR_W-1:0] addr_out,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              mreq_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic [DATA_W-1:0] rd_byte,
    output logic              busy,
    output logic              done
);
    localparam int CW = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(STROBE_CYC - 1);

    typedef enum logic [1:0] {S_IDLE, S_SETUP, S_STRB, S_RECOV} sstate_e;
    sstate_e           state;
    logic [ADDR_W-1:0] cur_addr;
    logic [LEN_W-1:0]  remain;
    logic [DATA_W-1:0] wbyte;
    logic [CW-1:0]     cnt;
    logic              wr_mode;
    logic              strm_mode;
    logic              go;

    assign go = start && (len != '0);

    // Purpose: pull the next stream byte at the start and before each later byte.
    always_comb begin
        stream_take = (go && src_stream) ||
                      (state == S_RECOV && strm_mode && remain != LEN_W'(1));
    end

    // Purpose: byte loop state, address counter, data latch and read capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            cur_addr  <= '0;
            remain    <= '0;
            wbyte     <= '0;
            cnt       <= '0;
            wr_mode   <= 1'b0;
            strm_mode <= 1'b0;
            data_oe   <= 1'b0;
            rd_byte   <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (go) begin
                        state     <= S_SETUP;
                        cur_addr  <= addr0;
                        remain    <= len;
                        wr_mode   <= is_write;
                        strm_mode <= src_stream;
                        wbyte     <= src_stream ? stream_data : fill_byte;
                        data_oe   <= is_write;
                    end else if (start) begin
                        done <= 1'b1;
                    end
                end
                S_SETUP: begin
                    state <= S_STRB;
                    cnt   <= '0;
                end
                S_STRB: begin
                    if (cnt == CNT_LAST) begin
                        state <= S_RECOV;
                        if (!wr_mode) rd_byte <= data_in;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                S_RECOV: begin
                    if (remain == LEN_W'(1)) begin
                        state   <= S_IDLE;
                        data_oe <= 1'b0;
                        done    <= 1'b1;
                    end else begin
                        state    <= S_SETUP;
                        remain   <= remain - LEN_W'(1);
                        cur_addr <= cur_addr + ADDR_W'(1);
                        if (stream_take) wbyte <= stream_data;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Purpose: strobe levels follow the strobe phase.
    always_comb begin
        mreq_n   = (state != S_STRB);
        rd_n     = !(state == S_STRB && !wr_mode);
        wr_n     = !(state == S_STRB && wr_mode);
        addr_out = cur_addr;
        data_out = wbyte;
        busy     = (state != S_IDLE);
    end
endmodule

// File: rtl/xbm_rstgen.sv
// Module: processor reset driver.
// Does: holds cpu_rst_n at a commanded level, or drives it low for exactly
// RST_CYC cycles and then releases it.
// Assumes: RST_CYC >= 1.
module xbm_rstgen #(
    parameter int RST_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_lvl,
    input  logic lvl,
    input  logic pulse,
    output logic cpu_rst_n,
    output logic busy,
    output logic done
);
    localparam int RW = (RST_CYC > 1) ? $clog2(RST_CYC) : 1;
    logic [RW-1:0] cnt;

    // Purpose: level set, pulse countdown and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_rst_n <= 1'b1;
            busy      <= 1'b0;
            cnt       <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (busy) begin
                if (cnt == '0) begin
                    cpu_rst_n <= 1'b1;
                    busy      <= 1'b0;
                    done      <= 1'b1;
                end else begin
                    cnt <= cnt - RW'(1);
                end
            end else if (pulse) begin
                cpu_rst_n <= 1'b0;
                busy      <= 1'b1;
                cnt       <= RW'(RST_CYC - 1);
            end else if (set_lvl) begin
                cpu_rst_n <= !lvl;
                done      <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/xbus_master.sv
// Module: bus-request memory access master (top).
// Does: decodes host commands, refuses memory accesses while the bus is not
// owned, and routes the rest to the ownership, cycle and reset units. It merges
// their completions into a single done/err pulse.
// Assumes: a command is offered only while cmd_ready is high; inputs are synchronous.
module xbus_master #(
    parameter int ADDR_W     = 19,
    parameter int DATA_W     = 8,
    parameter int LEN_W      = 16,
    parameter int STROBE_CYC = 2,
    parameter int RST_CYC    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [LEN_W-1:0]  cmd_len,
    output logic              cmd_ready,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] stream_data,
    output logic              stream_take,
    output logic              breq_n,
    input  logic              back_n,
    output logic [ADDR_W-1:0] addr_out,
    output logic              addr_oe,
    output logic [DATA_W-1:0] data_out,
    input  logic [DATA_W-1:0] data_in,
    output logic              data_oe,
    output logic              mreq_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic              cpu_rst_n
);
    import xbm_pkg::*;

    op_e              op;
    logic             accept, is_access, reject, start_seq;
    logic             owned, g_busy, g_done, s_busy, s_done, r_busy, r_done;
    logic [LEN_W-1:0] len_eff;

    // Purpose: decode the offered command.
    always_comb begin
        op        = op_e'(cmd_op);
        cmd_ready = !(g_busy || s_busy || r_busy);
        accept    = cmd_valid && cmd_ready;
        is_access = !cmd_op[2];
        reject    = accept && is_access && !owned;
        start_seq = accept && is_access && owned;
        len_eff   = cmd_op[1] ? cmd_len : LEN_W'(1);
    end

    xbm_grant u_grant (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (accept && op == OP_TAKE),
        .give    (accept && op == OP_GIVE),
        .back_n  (back_n),
        .breq_n  (breq_n),
        .addr_oe (addr_oe),
        .owned   (owned),
        .busy    (g_busy),
        .done    (g_done)
    );

    xbm_seq #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .LEN_W      (LEN_W),
        .STROBE_CYC (STROBE_CYC)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start_seq),
        .is_write    (op != OP_READ),
        .src_stream  (op == OP_STREAM),
        .addr0       (cmd_addr),
        .fill_byte   (cmd_data),
        .len         (len_eff),
        .stream_data (stream_data),
        .data_in     (data_in),
        .stream_take (stream_take),
        .addr_out    (addr_out),
        .data_out    (data_out),
        .data_oe     (data_oe),
        .mreq_n      (mreq_n),
        .rd_n        (rd_n),
        .wr_n        (wr_n),
        .rd_byte     (rd_data),
        .busy        (s_busy),
        .done        (s_done)
    );

    xbm_rstgen #(
        .RST_CYC (RST_CYC)
    ) u_rst (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_lvl   (accept && op == OP_RSTLVL),
        .lvl       (cmd_data[0]),
        .pulse     (accept && op == OP_RSTPULSE),
        .cpu_rst_n (cpu_rst_n),
        .busy      (r_busy),
        .done      (r_done)
    );

    // Purpose: merge completions into one registered done/err pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
            err  <= 1'b0;
        end else begin
            done <= g_done || s_done || r_done || reject;
            err  <= reject;
        end
    end
endmodule

// File: rtl/xbm_chk.sv
// Module: protocol checker for the bus-request memory master, bound to the top.
// Does: checks grant ordering, strobe pairing, setup and strobe width at the pins.
module xbm_chk #(
    parameter int ADDR_W     = 19,
    parameter int STROBE_CYC = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              breq_n,
    input logic              back_n,
    input logic              addr_oe,
    input logic [ADDR_W-1:0] addr_out,
    input logic              data_oe,
    input logic              mreq_n,
    input logic              rd_n,
    input logic              wr_n
);
    logic [7:0] low_run;

    // Purpose: count consecutive cycles with mreq_n low.
    always_ff @(posedge clk) begin
        if (!rst_n) low_run <= '0;
        else if (!mreq_n) low_run <= low_run + 8'd1;
        else low_run <= '0;
    end

    AST_OE_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n) $rose(addr_oe) |-> !$past(back_n)); // R2
    AST_OE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n) addr_oe |-> !breq_n); // R3
    AST_FLOAT_BEFORE_DROP: assert property (@(posedge clk) disable iff (!rst_n) $rose(breq_n) |-> !$past(addr_oe)); // R3
    AST_WR_PAIRED: assert property (@(posedge clk) disable iff (!rst_n) !wr_n |-> (!mreq_n && rd_n && data_oe)); // R4
    AST_RD_PAIRED: assert property (@(posedge clk) disable iff (!rst_n) !rd_n |-> (!mreq_n && wr_n && !data_oe)); // R5
    AST_ADDR_SETUP: assert property (@(posedge clk) disable iff (!rst_n) $fell(mreq_n) |-> ($past(addr_oe) && $stable(addr_out))); // R6
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!mreq_n && !$past(mreq_n)) |-> $stable(addr_out)); // R6
    AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) $rose(mreq_n) |-> (low_run == 8'(STROBE_CYC))); // R6
    AST_CYCLE_NEEDS_BUS: assert property (@(posedge clk) disable iff (!rst_n) !mreq_n |-> (addr_oe && !back_n)); // R10
endmodule

bind xbus_master xbm_chk #(
    .ADDR_W     (ADDR_W),
    .STROBE_CYC (STROBE_CYC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .breq_n   (breq_n),
    .back_n   (back_n),
    .addr_oe  (addr_oe),
    .addr_out (addr_out),
    .data_oe  (data_oe),
    .mreq_n   (mreq_n),
    .rd_n     (rd_n),
    .wr_n     (wr_n)
);

// File: tb/xbus_master_tb_top.sv
// Bench: directed scenarios against a processor model with a delayed grant
// and a small memory model.
module xbus_master_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int STROBE_CYC = 2;
    localparam int RST_CYC    = 16;
    localparam int GRANT_LAT  = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [18:0] cmd_addr = '0;
    logic [7:0]  cmd_data = '0;
    logic [15:0] cmd_len = '0;
    logic        cmd_ready, done, err, stream_take;
    logic [7:0]  rd_data, stream_data, data_out, data_in;
    logic        breq_n, back_n, addr_oe, data_oe, mreq_n, rd_n, wr_n, cpu_rst_n;
    logic [18:0] addr_out;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    logic [7:0] mem [1024];
    logic [7:0] src [8];
    int  take_idx = 0;
    logic [GRANT_LAT-1:0] ack_dly = '1;
    int  mreq_falls = 0;
    int  last_run = 0;
    int  run = 0;
    int  rst_low = 0;
    logic [18:0] last_addr = '0;
    logic viol_oe = 1'b0;
    logic viol_drop = 1'b0;
    logic prev_mreq = 1'b1;
    logic prev_oe = 1'b0;
    logic prev_breq = 1'b1;
    logic got_err;
    logic [7:0] got_rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    xbus_master #(.STROBE_CYC(STROBE_CYC), .RST_CYC(RST_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_len(cmd_len),
        .cmd_ready(cmd_ready), .done(done), .err(err), .rd_data(rd_data),
        .stream_data(stream_data), .stream_take(stream_take),
        .breq_n(breq_n), .back_n(back_n), .addr_out(addr_out), .addr_oe(addr_oe),
        .data_out(data_out), .data_in(data_in), .data_oe(data_oe),
        .mreq_n(mreq_n), .rd_n(rd_n), .wr_n(wr_n), .cpu_rst_n(cpu_rst_n)
    );

    assign back_n      = ack_dly[GRANT_LAT-1];
    assign data_in     = (!rd_n && !mreq_n) ? mem[addr_out[9:0]] : 8'h00;
    assign stream_data = src[take_idx[2:0]];

    // Processor and memory model plus protocol monitors.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        ack_dly <= {ack_dly[GRANT_LAT-2:0], breq_n};
        if (!wr_n && !mreq_n && data_oe) mem[addr_out[9:0]] <= data_out;
        if (stream_take) take_idx <= take_idx + 1;
        if (prev_mreq && !mreq_n) begin
            mreq_falls <= mreq_falls + 1;
            last_addr  <= addr_out;
        end
        if (!mreq_n) run <= run + 1;
        else begin
            if (!prev_mreq) last_run <= run;
            run <= 0;
        end
        if (!cpu_rst_n) rst_low <= rst_low + 1;
        if (rst_n && addr_oe && back_n) viol_oe <= 1'b1;
        if (rst_n && prev_breq == 1'b0 && breq_n && prev_oe) viol_drop <= 1'b1;
        prev_mreq <= mreq_n;
        prev_oe   <= addr_oe;
        prev_breq <= breq_n;
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic run_cmd(input logic [2:0] op, input logic [18:0] a,
                           input logic [7:0] d, input logic [15:0] n);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d; cmd_len = n;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            if (done) break;
            @(negedge clk);
        end
        got_err = err;
        got_rd  = rd_data;
        check("R2-R12 done seen", {31'd0, done}, 32'd1);
    endtask

    task automatic t_reset;
        check("R1 breq_n", {31'd0, breq_n}, 1);
        check("R1 strobes", {29'd0, mreq_n, rd_n, wr_n}, 32'h7);
        check("R1 drivers off", {30'd0, addr_oe, data_oe}, 0);
        check("R1 cpu_rst_n", {31'd0, cpu_rst_n}, 1);
        check("R1 cmd_ready", {31'd0, cmd_ready}, 1);
    endtask

    task automatic t_reject;
        int f0;
        f0 = mreq_falls;
        run_cmd(3'd1, 19'h10, 8'hAA, 16'd1);
        check("R10 err", {31'd0, got_err}, 1);
        run_cmd(3'd2, 19'h10, 8'hAA, 16'd4);
        check("R10 err fill", {31'd0, got_err}, 1);
        check("R10 no cycle", mreq_falls - f0, 0);
        check("R10 mem untouched", {24'd0, mem[10'h10]}, 0);
    endtask

    task automatic t_take;
        run_cmd(3'd4, '0, '0, '0);
        check("R2 err", {31'd0, got_err}, 0);
        check("R2 breq_n low", {31'd0, breq_n}, 0);
        check("R2 addr_oe", {31'd0, addr_oe}, 1);
        check("R2 ack low", {31'd0, back_n}, 0);
        check("R2 no early drive", {31'd0, viol_oe}, 0);
    endtask

    task automatic t_write_read;
        int f0;
        f0 = mreq_falls;
        run_cmd(3'd1, 19'h123, 8'h5C, 16'd0);
        check("R4 mem", {24'd0, mem[10'h123]}, 32'h5C);
        check("R4 one cycle", mreq_falls - f0, 1);
        check("R4 addr", {13'd0, last_addr}, 32'h123);
        check("R6 strobe width", last_run, STROBE_CYC);
        check("R4 data released", {31'd0, data_oe}, 0);
        mem[10'h2A7] = 8'hC3;
        run_cmd(3'd0, 19'h2A7, 8'h00, 16'd0);
        check("R5 rd_data", {24'd0, got_rd}, 32'hC3);
        check("R5 addr", {13'd0, last_addr}, 32'h2A7);
        check("R6 strobe width rd", last_run, STROBE_CYC);
    endtask

    task automatic t_fill;
        int f0;
        f0 = mreq_falls;
        run_cmd(3'd2, 19'h0F0, 8'h77, 16'd5);
        for (int i = 0; i < 5; i++) check("R7 fill byte", {24'd0, mem[10'h0F0 + i]}, 32'h77);
        check("R7 below untouched", {24'd0, mem[10'h0EF]}, 0);
        check("R7 above untouched", {24'd0, mem[10'h0F5]}, 0);
        check("R7 cycle count", mreq_falls - f0, 5);
        check("R7 last addr", {13'd0, last_addr}, 32'h0F4);
        f0 = mreq_falls;
        run_cmd(3'd2, 19'h300, 8'h99, 16'd0);
        check("R9 no cycle", mreq_falls - f0, 0);
        check("R9 err", {31'd0, got_err}, 0);
        check("R9 mem", {24'd0, mem[10'h300]}, 0);
    endtask

    task automatic t_stream;
        int f0, t0;
        f0 = mreq_falls; t0 = take_idx;
        run_cmd(3'd3, 19'h200, 8'h00, 16'd4);
        for (int i = 0; i < 4; i++) check("R8 stream byte", {24'd0, mem[10'h200 + i]}, {24'd0, src[i]});
        check("R8 takes", take_idx - t0, 4);
        check("R8 cycles", mreq_falls - f0, 4);
    endtask

    task automatic t_top_addr;
        run_cmd(3'd1, 19'h7FFFF, 8'hE1, 16'd0);
        check("R11 full address", {13'd0, last_addr}, 32'h7FFFF);
        check("R11 mem", {24'd0, mem[10'h3FF]}, 32'hE1);
    endtask

    task automatic t_give;
        run_cmd(3'd5, '0, '0, '0);
        check("R3 ack high at done", {31'd0, back_n}, 1);
        check("R3 breq_n high", {31'd0, breq_n}, 1);
        check("R3 addr_oe off", {31'd0, addr_oe}, 0);
        check("R3 order", {31'd0, viol_drop}, 0);
        check("R3 no drive w/o ack", {31'd0, viol_oe}, 0);
    endtask

    task automatic t_cpu_reset;
        run_cmd(3'd6, '0, 8'h01, '0);
        check("R12 level assert", {31'd0, cpu_rst_n}, 0);
        run_cmd(3'd6, '0, 8'h00, '0);
        check("R12 level release", {31'd0, cpu_rst_n}, 1);
        rst_low = 0;
        run_cmd(3'd7, '0, '0, '0);
        check("R12 pulse width", rst_low, RST_CYC);
        check("R12 released", {31'd0, cpu_rst_n}, 1);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        for (int i = 0; i < 8; i++) src[i] = 8'(8'h31 * (i + 1));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reject();
        t_take();
        t_write_read();
        t_fill();
        t_stream();
        t_top_addr();
        t_give();
        t_reject();
        t_cpu_reset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait (cyc >= 100000);
        errors++;
        checks++;
        $display("FAIL watchdog (R1-R12 run) actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule